// File: doc/BRIEF.md
# Reloading Countdown Timer with Interrupt Request Latch

The block is a single timer channel with its interrupt logic. A 16-bit counter steps down by one on each count-enable tick, which normally comes from a 2 MHz prescaler. The counter starts stepping as soon as reset is released. When a tick arrives while the count is zero, the counter reloads from a programmable reload latch, and that reload marks a timer event. Each event sets a sticky request bit. A mask bit gates that request onto a registered, level-sensitive `irq_o`. Software acknowledges the request by writing a clear register.

Software reaches the block over a small synchronous register bus made of an address, a write strobe, write data and combinational read data. The reload latch is written one byte at a time. A new latch value takes effect at the next zero crossing, so no start command is needed. A write to the restart register loads the counter from the latch at once and restarts the period. After reset both the latch and the count are zero, so a request is raised on every tick. Unmasking the interrupt therefore exposes a request that is already pending.

Top module: `tmr_irq_unit`

## Requirements
- R1: On a clock edge with `tick_i` high and no restart write, a nonzero count decreases by one. With `tick_i` low and no restart write, the count holds. Counting begins right after reset without any start command.
- R2: On a clock edge with `tick_i` high while the count is 0, the counter loads the latch value, so the period is latch+1 ticks. With latch 0 the counter reloads, and raises an event, on every tick.
- R3: Writing address 4 sets latch bits 7:0 and writing address 5 sets latch bits 15:8. Neither write changes the current count. The new value is used at the next reload.
- R4: A write of any data to address 6 loads the count from the latch on that clock edge and takes priority over the tick. The restart write does not set the request bit by itself.
- R5: Each tick that finds the count at 0 sets the request bit, which is bit 6, on the same edge. The bit stays set until it is cleared.
- R6: Writing address 3 with data bit 6 = 1 clears the request bit. Data bit 6 = 0 has no effect. If a reload event happens on the same edge as a clear, the request stays set.
- R7: Mask bit 6 is written at address 2. `irq_o` is a register that, one edge later, follows request AND mask. Setting the mask while a request is pending raises `irq_o` on the next edge.
- R8: Read data: address 0 gives the raw request in bit 6, address 1 gives request AND mask in bit 6, address 2 gives the mask in bit 6, address 4 gives count bits 7:0 and address 5 gives count bits 15:8. All other bits and addresses read 0.
- R9: After reset the count, latch, request, mask and `irq_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count-enable tick (2 MHz rate) |
| addr_i | input | 3 | Register address |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` |
| irq_o | output | 1 | Registered level interrupt |

## Verification
The bench targets the zero latch after reset. A design that waited for a start command, or skipped the reload at zero, would never raise a request there. A latch byte written in mid-count must leave the count readback unchanged; a design that loaded the counter on a latch write would show the new value at once. Bench cycles also put a clear write on the same edge as a zero-crossing tick. A design that let the clear win would drop that event, and unmasking a pending request must raise `irq_o` exactly one edge later. A restart write is also checked when it coincides with a tick, and it must win over both the decrement and the reload.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int ADDR_W  = 3;
  localparam int DATA_W  = 8;
  localparam int CNT_W   = 16;
  localparam int IRQ_BIT = 6;

  localparam logic [ADDR_W-1:0] ADR_RAW   = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_PEND  = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_MASK  = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_CLR   = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_BYTE0 = 3'd4;  // byte i of latch/count at ADR_BYTE0+i
  localparam logic [ADDR_W-1:0] ADR_GO    = 3'd6;
endpackage

// File: rtl/tmr_bus_dec.sv
module tmr_bus_dec
  import tmr_pkg::*;
#(
  parameter int NB = CNT_W / DATA_W
) (
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               we_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [CNT_W-1:0]   cnt_i,
  input  logic               req_i,
  input  logic               mask_i,
  output logic [NB-1:0]      ld_byte_o,
  output logic               go_o,
  output logic               clr_o,
  output logic               mask_we_o,
  output logic               mask_val_o,
  output logic [DATA_W-1:0]  rdata_o
);
  for (genvar i = 0; i < NB; i++) begin : g_ld
    assign ld_byte_o[i] = we_i && (addr_i == ADR_BYTE0 + ADDR_W'(i));
  end

  assign go_o       = we_i && (addr_i == ADR_GO);
  assign clr_o      = we_i && (addr_i == ADR_CLR) && wdata_i[IRQ_BIT];
  assign mask_we_o  = we_i && (addr_i == ADR_MASK);
  assign mask_val_o = wdata_i[IRQ_BIT];

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADR_RAW:  rdata_o[IRQ_BIT] = req_i;
      ADR_PEND: rdata_o[IRQ_BIT] = req_i & mask_i;
      ADR_MASK: rdata_o[IRQ_BIT] = mask_i;
      default: begin
        for (int i = 0; i < NB; i++) begin
          if (addr_i == ADR_BYTE0 + ADDR_W'(i)) rdata_o = cnt_i[i*DATA_W +: DATA_W];
        end
      end
    endcase
  end
endmodule

// File: rtl/tmr_reload_cnt.sv
module tmr_reload_cnt
  import tmr_pkg::*;
#(
  parameter int NB = CNT_W / DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [NB-1:0]     ld_byte_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              go_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              evt_o
);
  logic [CNT_W-1:0] latch_q, cnt_q;

  for (genvar i = 0; i < NB; i++) begin : g_latch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           latch_q[i*DATA_W +: DATA_W] <= '0;
      else if (ld_byte_i[i]) latch_q[i*DATA_W +: DATA_W] <= wdata_i;
    end
  end

  wire cnt_zero = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (go_i)   cnt_q <= latch_q;
    else if (tick_i) cnt_q <= cnt_zero ? latch_q : cnt_q - 1'b1;
  end

  assign evt_o = tick_i && cnt_zero;
  assign cnt_o = cnt_q;

  // R1
  dec_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !go_i && !cnt_zero |=> cnt_q == CNT_W'($past(cnt_q) - 1'b1));
  // R1
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i && !go_i |=> $stable(cnt_q));
  // R2
  zero_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !go_i && cnt_zero |=> cnt_q == $past(latch_q));
  // R4
  go_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_i |=> cnt_q == $past(latch_q));
endmodule

// File: rtl/tmr_irq_ctl.sv
module tmr_irq_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  input  logic clr_i,
  input  logic mask_we_i,
  input  logic mask_val_i,
  output logic req_o,
  output logic mask_o,
  output logic irq_o
);
  logic req_q, mask_q, irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      mask_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      req_q <= evt_i | (req_q & ~clr_i);  // set beats clear
      if (mask_we_i) mask_q <= mask_val_i;
      irq_q <= req_q & mask_q;
    end
  end

  assign req_o  = req_q;
  assign mask_o = mask_q;
  assign irq_o  = irq_q;

  // R5
  evt_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i |=> req_q);
  // R6
  clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !evt_i |=> !req_q);
  // R5
  req_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q && !clr_i |=> req_q);
  // R7
  irq_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> irq_q == ($past(req_q) && $past(mask_q)));
endmodule

// File: rtl/tmr_irq_unit.sv
module tmr_irq_unit
  import tmr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam int NB = CNT_W / DATA_W;

  logic [NB-1:0]    ld_byte;
  logic             go, clr, mask_we, mask_val, evt, req, mask;
  logic [CNT_W-1:0] cnt;

  tmr_bus_dec #(.NB(NB)) i_dec (
    .addr_i(addr_i), .we_i(we_i), .wdata_i(wdata_i), .cnt_i(cnt),
    .req_i(req), .mask_i(mask), .ld_byte_o(ld_byte), .go_o(go),
    .clr_o(clr), .mask_we_o(mask_we), .mask_val_o(mask_val), .rdata_o(rdata_o)
  );

  tmr_reload_cnt #(.NB(NB)) i_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .ld_byte_i(ld_byte),
    .wdata_i(wdata_i), .go_i(go), .cnt_o(cnt), .evt_o(evt)
  );

  tmr_irq_ctl i_irq (
    .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt), .clr_i(clr),
    .mask_we_i(mask_we), .mask_val_i(mask_val), .req_o(req),
    .mask_o(mask), .irq_o(irq_o)
  );

  // R4
  go_no_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go && !evt && !req |=> !req);
endmodule

// File: tb/test_tmr_irq_unit.sv
module test_tmr_irq_unit;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick = 1'b0;
  logic [2:0] addr = '0;
  logic       we = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq;

  int checks = 0;
  int errors = 0;

  // bench model state
  logic [15:0] m_cnt, m_latch;
  logic        m_req, m_mask, m_irq;

  tmr_irq_unit i_tmr_irq_unit (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .addr_i(addr),
    .we_i(we), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  always #5 clk = ~clk;

  function automatic logic [7:0] exp_read(input logic [2:0] a);
    case (a)
      3'd0: return {1'b0, m_req, 6'b0};
      3'd1: return {1'b0, m_req & m_mask, 6'b0};
      3'd2: return {1'b0, m_mask, 6'b0};
      3'd4: return m_cnt[7:0];
      3'd5: return m_cnt[15:8];
      default: return 8'h00;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] a);
    case (a)
      3'd0: return "R5";
      3'd1: return "R7";
      3'd2: return "R7";
      3'd4: return "R1";
      3'd5: return "R3";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // drive one cycle, check outputs against model, then advance the model
  task automatic step(input logic t, input logic w, input logic [2:0] a, input logic [7:0] d);
    logic evt, clr;
    @(negedge clk);
    tick = t; we = w; addr = a; wdata = d;
    #1;
    check(tag_of(a), {8'h00, rdata}, {8'h00, exp_read(a)});
    check("R7", {15'd0, irq}, {15'd0, m_irq});
    @(posedge clk);
    evt = t && (m_cnt == 16'd0);
    clr = w && a == 3'd3 && d[6];
    m_irq = m_req & m_mask;
    m_req = evt | (m_req & ~clr);
    if (w && a == 3'd6)  m_cnt = m_latch;
    else if (t)          m_cnt = (m_cnt == 16'd0) ? m_latch : m_cnt - 16'd1;
    if (w && a == 3'd2)  m_mask = d[6];
    if (w && a == 3'd4)  m_latch[7:0] = d;
    if (w && a == 3'd5)  m_latch[15:8] = d;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd12345));
    m_cnt = '0; m_latch = '0; m_req = 0; m_mask = 0; m_irq = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R9 reset state
    @(negedge clk); #1;
    check("R9", {8'h00, rdata}, 16'h0000);
    check("R9", {15'd0, irq}, 16'd0);
    for (int a = 0; a < 8; a++) step(1'b0, 1'b0, 3'(a), 8'h00);

    // R2 zero latch reloads every tick, R5 raises request without setup
    step(1'b1, 1'b0, 3'd0, 8'h00);
    step(1'b0, 1'b0, 3'd0, 8'h00);
    check("R5", {15'd0, m_req}, 16'd1);
    // R6 clear with bit 6 low has no effect
    step(1'b0, 1'b1, 3'd3, 8'hBF);
    step(1'b0, 1'b0, 3'd0, 8'h00);
    // R7 unmask a pending request
    step(1'b0, 1'b1, 3'd2, 8'h40);
    step(1'b0, 1'b0, 3'd1, 8'h00);
    step(1'b0, 1'b0, 3'd1, 8'h00);
    check("R7", {15'd0, irq}, 16'd1);
    // R6 clear and zero tick on the same edge: set wins
    step(1'b1, 1'b1, 3'd3, 8'h40);
    step(1'b0, 1'b0, 3'd0, 8'h00);
    step(1'b0, 1'b1, 3'd3, 8'h40);
    step(1'b0, 1'b0, 3'd0, 8'h00);
    // R3 latch write does not disturb count
    step(1'b0, 1'b1, 3'd4, 8'h05);
    step(1'b0, 1'b0, 3'd4, 8'h00);
    step(1'b0, 1'b1, 3'd5, 8'h01);
    step(1'b0, 1'b0, 3'd5, 8'h00);
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 3'd4, 8'h00);
    // R4 restart with a tick on the same edge
    step(1'b1, 1'b1, 3'd6, 8'h00);
    step(1'b0, 1'b0, 3'd5, 8'h00);
    step(1'b0, 1'b0, 3'd4, 8'h00);
    // R4 restart on an idle, unrequested counter raises nothing
    step(1'b0, 1'b1, 3'd3, 8'h40);
    step(1'b0, 1'b1, 3'd6, 8'hFF);
    step(1'b0, 1'b0, 3'd0, 8'h00);
    // short period
    step(1'b0, 1'b1, 3'd5, 8'h00);
    step(1'b0, 1'b1, 3'd4, 8'h03);
    step(1'b0, 1'b1, 3'd6, 8'h00);

    for (int n = 0; n < 4000; n++) begin
      logic       t, w;
      logic [2:0] a;
      logic [7:0] d;
      t = ($urandom % 3) == 0;
      w = ($urandom % 4) == 0;
      a = 3'($urandom % 8);
      d = 8'($urandom);
      if (w && a == 3'd5) d = d & 8'h00;   // keep periods short
      if (w && a == 3'd4) d = d & 8'h0F;
      step(t, w, a, d);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule